// File: doc/BRIEF.md
# BCD Real-Time Clock Calendar

This block keeps wall-clock time and calendar date in BCD. It has no oscillator. A one-cycle `tick` strobe that arrives once per second advances it. Each tick starts a short ripple through the fields in a fixed order: seconds, then minutes, then hours, then date together with day of week, then month, then year. The ripple moves on to the next field only when the current field wraps, so a normal tick touches only the seconds. The century flag toggles when the year wraps. Each wrap raises a one-cycle carry pulse, so that alarm or compare logic downstream can sample the newly settled fields.

A controller in the ripple drives the sequence. Its states are `ST_IDLE`, `ST_SEC`, `ST_MIN`, `ST_HOUR`, `ST_DAY`, `ST_MON` and `ST_YEAR`. It has these transitions:
- `ST_IDLE` goes to `ST_SEC` on `tick`.
- Each stepping state goes to the next field's state when its field wraps.
- Each stepping state returns to `ST_IDLE` when its field does not wrap, or when the host writes that field in the same cycle.
- `ST_YEAR` always returns to `ST_IDLE`.

A `tick` that arrives while the controller is away from `ST_IDLE` is ignored. At one tick per second this cannot happen in use.

A host write port loads any register in one cycle. A combinational read port returns any register. Register addresses:
- 0: seconds
- 1: minutes
- 2: hours, where bit 7 = 1 selects 24-hour mode and bit 5 is the PM flag in 12-hour mode
- 3: date
- 4: month
- 5: two-digit year
- 6: day of week
- 7: century flag, in bit 0

Top module: `rtc_core`

## Requirements
- R1: After reset the registers read as follows: seconds 0x00, minutes 0x00, hours 0x80 (24-hour mode, hour 00), date 0x01, month 0x01, year 0x00, day of week 0x00, century 0x01. All carry outputs are 0.
- R2: Seconds and minutes count in BCD from 0x00 to 0x59. The step from 0x59 goes to 0x00, raises a carry and passes the step on to the next field.
- R3: In 24-hour mode (hour bit 7 = 1), the hour counts 0x00 to 0x23. The step from 0x23 goes to 0x00, keeps bit 7 set, and passes a carry on to the date.
- R4: In 12-hour mode (hour bit 7 = 0), bits 4:0 count 12, 01, …, 11 in BCD and bit 5 is PM. The step from 11 to 12 flips bit 5. The date advances only when 11 PM steps to 12 AM. The step from 12 goes to 01 and leaves bit 5 unchanged.
- R5: Months 0x04, 0x06, 0x09 and 0x11 end after date 0x30. The other months, except February, end after 0x31. Past the last day the date returns to 0x01 and the month advances.
- R6: February ends after 0x29 when the two-digit year is divisible by 4 (00 counts as divisible). In every other year it ends after 0x28.
- R7: The month steps 0x12 to 0x01 and advances the year. The year steps 0x99 to 0x00 and flips century bit 0.
- R8: Day of week advances whenever the date advances, and steps 6 to 0.
- R9: When the host writes the field being stepped in the same cycle, the written value is stored and the ripple stops. No carry is raised and no later field changes.
- R10: A tick accepted at clock edge n updates seconds at edge n+1. Each further field in the ripple updates one edge after the previous one. Carry bits are, in order, bit 0 seconds, bit 1 minutes, bit 2 hours, bit 3 date, bit 4 month and bit 5 year. The bit for a field is high for exactly the one cycle after that field's wrapping update, and at most one carry bit is ever high.
- R11: `rd_data` shows the register at `rd_addr` in the same cycle. Bits a register does not implement read 0: for example, writing 0xFF to the century register reads back 0x01.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle once-per-second advance strobe |
| wr_en | input | 1 | Host write strobe |
| wr_addr | input | 3 | Host write register address |
| wr_data | input | 8 | Host write data |
| rd_addr | input | 3 | Read register address |
| rd_data | output | 8 | Read data, combinational |
| carry_o | output | 6 | One-cycle rollover pulses, one bit per field |

## Verification
The bench drives a full rollover from 23:59:59 on 31 December of year 99. A design with a bad ripple order, a wrong latency or a missed century flip shows a carry in the wrong cycle or a stale field. It runs 30-day and February month ends in leap years (24, 00) and in a non-leap year (23). A wrong month-length table either skips to the first of the month too early or reaches a date 0x29/0x30 that does not exist. It walks 12-hour mode through 11 AM, 11 PM and 12. A design that flips PM at the wrong step or advances the date at noon gives a wrong hour code or date. Finally, it writes the seconds in the very cycle they are being stepped. A design without write priority would keep the stepped value or carry into the minutes.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
    localparam int DW = 8;
    localparam int AW = 3;
    localparam int NCARRY = 6;

    typedef enum logic [2:0] {
        ST_IDLE, ST_SEC, ST_MIN, ST_HOUR, ST_DAY, ST_MON, ST_YEAR
    } step_t;

    localparam logic [AW-1:0] A_SEC  = 3'd0;
    localparam logic [AW-1:0] A_MIN  = 3'd1;
    localparam logic [AW-1:0] A_HOUR = 3'd2;
    localparam logic [AW-1:0] A_DATE = 3'd3;
    localparam logic [AW-1:0] A_MON  = 3'd4;
    localparam logic [AW-1:0] A_YEAR = 3'd5;
    localparam logic [AW-1:0] A_WDAY = 3'd6;
    localparam logic [AW-1:0] A_CEN  = 3'd7;

    localparam logic [DW-1:0] M_SEC  = 8'h7F;
    localparam logic [DW-1:0] M_MIN  = 8'h7F;
    localparam logic [DW-1:0] M_HOUR = 8'hBF;
    localparam logic [DW-1:0] M_DATE = 8'h3F;
    localparam logic [DW-1:0] M_MON  = 8'h1F;
    localparam logic [DW-1:0] M_YEAR = 8'hFF;
    localparam logic [DW-1:0] M_WDAY = 8'h07;
    localparam logic [DW-1:0] M_CEN  = 8'h01;

    function automatic logic [6:0] bcd_to_bin(input logic [7:0] b);
        return 7'(b[7:4]) * 7'd10 + 7'(b[3:0]);
    endfunction

    function automatic logic [7:0] bin_to_bcd(input logic [6:0] v);
        logic [3:0] t;
        logic [3:0] o;
        t = 4'(v / 7'd10);
        o = 4'(v % 7'd10);
        return {t, o};
    endfunction
endpackage

// File: rtl/rtc_bcd_step.sv
module rtc_bcd_step
    import rtc_pkg::*;
#(
    parameter int W = DW
) (
    input  logic [W-1:0] cur,
    input  logic [W-1:0] lo,
    input  logic [W-1:0] hi,
    output logic [W-1:0] nxt,
    output logic         wrap
);
    logic [6:0] cur_b;
    logic [6:0] hi_b;

    always_comb begin
        cur_b = bcd_to_bin(8'(cur));
        hi_b  = bcd_to_bin(8'(hi));
        if (cur_b >= hi_b) begin
            nxt  = lo;
            wrap = 1'b1;
        end else begin
            nxt  = W'(bin_to_bcd(cur_b + 7'd1));
            wrap = 1'b0;
        end
    end
endmodule

// File: rtl/rtc_month_days.sv
module rtc_month_days
    import rtc_pkg::*;
(
    input  logic [DW-1:0] month,
    input  logic [DW-1:0] year,
    output logic [DW-1:0] last_day
);
    logic leap;

    always_comb begin
        if (year[4] == 1'b0)
            leap = (year[3:0] == 4'd0) || (year[3:0] == 4'd4) || (year[3:0] == 4'd8);
        else
            leap = (year[3:0] == 4'd2) || (year[3:0] == 4'd6);
        unique case (month)
            8'h02:                      last_day = leap ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: last_day = 8'h30;
            default:                    last_day = 8'h31;
        endcase
    end
endmodule

// File: rtl/rtc_hour_step.sv
module rtc_hour_step
    import rtc_pkg::*;
(
    input  logic [DW-1:0] cur,
    output logic [DW-1:0] nxt,
    output logic          wrap
);
    logic [6:0] v;
    logic       pm_n;
    logic [6:0] h_n;
    logic [7:0] h_bcd;

    always_comb begin
        nxt   = cur;
        wrap  = 1'b0;
        pm_n  = cur[5];
        h_n   = 7'd0;
        h_bcd = 8'h00;
        if (cur[7]) begin
            v = bcd_to_bin({2'b00, cur[5:0]});
            if (v >= 7'd23) begin
                h_n  = 7'd0;
                wrap = 1'b1;
            end else begin
                h_n = v + 7'd1;
            end
            h_bcd = bin_to_bcd(h_n);
            nxt   = {2'b10, h_bcd[5:0]};
        end else begin
            v = bcd_to_bin({3'b000, cur[4:0]});
            if (v >= 7'd12 || v == 7'd0) begin
                h_n = 7'd1;
            end else if (v == 7'd11) begin
                h_n  = 7'd12;
                pm_n = ~cur[5];
                wrap = cur[5];
            end else begin
                h_n = v + 7'd1;
            end
            h_bcd = bin_to_bcd(h_n);
            nxt   = {2'b00, pm_n, h_bcd[4:0]};
        end
    end
endmodule

// File: rtl/rtc_core.sv
module rtc_core
    import rtc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [DW-1:0]     wr_data,
    input  logic [AW-1:0]     rd_addr,
    output logic [DW-1:0]     rd_data,
    output logic [NCARRY-1:0] carry_o
);
    step_t state, state_nx;

    logic [DW-1:0] sec_q, min_q, hour_q, date_q, mon_q, year_q, wday_q, cen_q;

    logic [DW-1:0] f_cur, f_lo, f_hi, f_nxt;
    logic          f_wrap;
    logic [DW-1:0] h_nxt;
    logic          h_wrap;
    logic [DW-1:0] w_nxt;
    logic          w_wrap;
    logic [DW-1:0] last_day;
    logic [AW-1:0] f_addr;
    logic          f_written;
    logic          step_wrap;

    rtc_bcd_step #(.W(DW)) u_field (
        .cur(f_cur), .lo(f_lo), .hi(f_hi), .nxt(f_nxt), .wrap(f_wrap)
    );

    rtc_bcd_step #(.W(DW)) u_wday (
        .cur(wday_q), .lo(8'h00), .hi(8'h06), .nxt(w_nxt), .wrap(w_wrap)
    );

    rtc_hour_step u_hour (
        .cur(hour_q), .nxt(h_nxt), .wrap(h_wrap)
    );

    rtc_month_days u_mdays (
        .month(mon_q), .year(year_q), .last_day(last_day)
    );

    // Select the field being stepped and its limits
    always_comb begin
        f_cur  = sec_q;
        f_lo   = 8'h00;
        f_hi   = 8'h59;
        f_addr = A_SEC;
        unique case (state)
            ST_IDLE: ;
            ST_SEC:  ;
            ST_MIN:  begin f_cur = min_q;  f_addr = A_MIN;  end
            ST_HOUR: begin f_cur = hour_q; f_addr = A_HOUR; end
            ST_DAY:  begin f_cur = date_q; f_lo = 8'h01; f_hi = last_day; f_addr = A_DATE; end
            ST_MON:  begin f_cur = mon_q;  f_lo = 8'h01; f_hi = 8'h12;    f_addr = A_MON;  end
            ST_YEAR: begin f_cur = year_q; f_hi = 8'h99; f_addr = A_YEAR; end
            default: ;
        endcase
        f_written = wr_en && (wr_addr == f_addr);
        step_wrap = (state == ST_HOUR) ? h_wrap : f_wrap;
    end

    // Next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: state_nx = tick ? ST_SEC : ST_IDLE;
            ST_SEC:  state_nx = (step_wrap && !f_written) ? ST_MIN  : ST_IDLE;
            ST_MIN:  state_nx = (step_wrap && !f_written) ? ST_HOUR : ST_IDLE;
            ST_HOUR: state_nx = (step_wrap && !f_written) ? ST_DAY  : ST_IDLE;
            ST_DAY:  state_nx = (step_wrap && !f_written) ? ST_MON  : ST_IDLE;
            ST_MON:  state_nx = (step_wrap && !f_written) ? ST_YEAR : ST_IDLE;
            ST_YEAR: state_nx = ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Field registers and carry pulses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sec_q   <= 8'h00;
            min_q   <= 8'h00;
            hour_q  <= 8'h80;
            date_q  <= 8'h01;
            mon_q   <= 8'h01;
            year_q  <= 8'h00;
            wday_q  <= 8'h00;
            cen_q   <= 8'h01;
            carry_o <= '0;
        end else begin
            carry_o <= '0;
            if (!f_written) begin
                unique case (state)
                    ST_IDLE: ;
                    ST_SEC:  begin sec_q <= f_nxt;  carry_o[0] <= f_wrap; end
                    ST_MIN:  begin min_q <= f_nxt;  carry_o[1] <= f_wrap; end
                    ST_HOUR: begin hour_q <= h_nxt; carry_o[2] <= h_wrap; end
                    ST_DAY: begin
                        date_q     <= f_nxt;
                        carry_o[3] <= f_wrap;
                        wday_q     <= w_nxt;
                    end
                    ST_MON:  begin mon_q <= f_nxt; carry_o[4] <= f_wrap; end
                    ST_YEAR: begin
                        year_q     <= f_nxt;
                        carry_o[5] <= f_wrap;
                        if (f_wrap) cen_q <= {7'd0, ~cen_q[0]};
                    end
                    default: ;
                endcase
            end
            if (wr_en) begin
                unique case (wr_addr)
                    A_SEC:  sec_q  <= wr_data & M_SEC;
                    A_MIN:  min_q  <= wr_data & M_MIN;
                    A_HOUR: hour_q <= wr_data & M_HOUR;
                    A_DATE: date_q <= wr_data & M_DATE;
                    A_MON:  mon_q  <= wr_data & M_MON;
                    A_YEAR: year_q <= wr_data & M_YEAR;
                    A_WDAY: wday_q <= wr_data & M_WDAY;
                    A_CEN:  cen_q  <= wr_data & M_CEN;
                    default: ;
                endcase
            end
        end
    end

    // Read port
    always_comb begin
        unique case (rd_addr)
            A_SEC:   rd_data = sec_q;
            A_MIN:   rd_data = min_q;
            A_HOUR:  rd_data = hour_q;
            A_DATE:  rd_data = date_q;
            A_MON:   rd_data = mon_q;
            A_YEAR:  rd_data = year_q;
            A_WDAY:  rd_data = wday_q;
            A_CEN:   rd_data = cen_q;
            default: rd_data = '0;
        endcase
    end

    // R10: an accepted tick starts the ripple at the seconds
    a_r10_tick_start: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && tick) |=> (state == ST_SEC));

    // R10: rollover pulses never overlap
    a_r10_carry_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(carry_o));

    // R9: a host write lands unchanged even while that field is stepped
    a_r9_sec_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == A_SEC) |=> (sec_q == ($past(wr_data) & M_SEC)));

    // R2: a stepped second is always a legal BCD value
    a_r2_sec_range: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SEC && !(wr_en && wr_addr == A_SEC))
        |=> (sec_q <= 8'h59 && sec_q[3:0] <= 4'd9));

    // R3: a stepped 24-hour value stays within 00..23
    a_r3_hour24_range: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HOUR && hour_q[7] && !(wr_en && wr_addr == A_HOUR))
        |=> (hour_q[7] && hour_q[5:0] <= 6'h23));

    // R7: a year carry comes with a century flip
    a_r7_century_flip: assert property (@(posedge clk) disable iff (!rst_n)
        (carry_o[5] && !$past(wr_en && wr_addr == A_CEN))
        |-> (cen_q[0] != $past(cen_q[0])));
endmodule

// File: tb/sim_rtc_core.sv
module sim_rtc_core;
    import rtc_pkg::*;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              tick = 1'b0;
    logic              wr_en = 1'b0;
    logic [AW-1:0]     wr_addr = '0;
    logic [DW-1:0]     wr_data = '0;
    logic [AW-1:0]     rd_addr = '0;
    logic [DW-1:0]     rd_data;
    logic [NCARRY-1:0] carry_o;

    always #10 clk = ~clk;

    rtc_core u0 (
        .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
        .rd_data(rd_data), .carry_o(carry_o)
    );

    typedef struct {
        logic [AW-1:0] a;
        logic [DW-1:0] v;
        string         tag;
    } item_t;

    item_t q[$];
    int    pending = 0;
    int    n_run = 0;
    int    n_fail = 0;
    logic [NCARRY-1:0] clog [8];

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Scoreboard monitor: pops expected register values and compares
    always begin
        @(negedge clk);
        while (q.size() > 0) begin
            item_t it;
            it = q.pop_front();
            rd_addr = it.a;
            #1;
            chk(it.tag, rd_data, it.v);
            pending--;
        end
    end

    task automatic expect_reg(input logic [AW-1:0] a, input logic [7:0] v, input string tag);
        item_t it;
        it.a = a; it.v = v; it.tag = tag;
        pending++;
        q.push_back(it);
    endtask

    task automatic settle();
        wait (pending == 0);
        @(negedge clk);
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_tick();
        @(negedge clk);
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
        clog[0] = carry_o;
        for (int i = 1; i < 8; i++) begin
            @(negedge clk);
            clog[i] = carry_o;
        end
    endtask

    // depth = number of fields that wrapped; bit k-1 expected at sample k
    task automatic check_carry(input int depth, input string tag);
        for (int i = 0; i < 8; i++) begin
            logic [7:0] e;
            e = (i >= 1 && i <= depth) ? 8'(1 << (i - 1)) : 8'h00;
            chk(tag, 8'(clog[i]), e);
        end
    endtask

    task automatic set_clock(input logic [7:0] h, input logic [7:0] m, input logic [7:0] s);
        wr(A_HOUR, h); wr(A_MIN, m); wr(A_SEC, s);
    endtask

    initial begin
        fork
            begin
                repeat (100000) @(posedge clk);
                n_fail++;
                $display("FAIL watchdog expired");
                $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
                $finish;
            end
        join_none

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        expect_reg(A_SEC, 8'h00, "R1 sec");
        expect_reg(A_MIN, 8'h00, "R1 min");
        expect_reg(A_HOUR, 8'h80, "R1 hour");
        expect_reg(A_DATE, 8'h01, "R1 date");
        expect_reg(A_MON, 8'h01, "R1 month");
        expect_reg(A_YEAR, 8'h00, "R1 year");
        expect_reg(A_WDAY, 8'h00, "R1 wday");
        expect_reg(A_CEN, 8'h01, "R1 century");
        settle();
        chk("R1 carry", 8'(carry_o), 8'h00);

        // R2 plain second step, no carry
        set_clock(8'h80, 8'h05, 8'h58);
        do_tick();
        check_carry(0, "R2 no carry");
        expect_reg(A_SEC, 8'h59, "R2 sec 58->59");
        settle();

        // R2 second rollover into minutes only
        do_tick();
        check_carry(2 - 1, "R2 sec carry");
        expect_reg(A_SEC, 8'h00, "R2 sec wrap");
        expect_reg(A_MIN, 8'h06, "R2 min step");
        settle();

        // Full ripple: R3 R5 R7 R8 R10
        set_clock(8'hA3, 8'h59, 8'h59);
        wr(A_DATE, 8'h31); wr(A_MON, 8'h12); wr(A_YEAR, 8'h99); wr(A_WDAY, 8'h06);
        do_tick();
        check_carry(6, "R10 ripple carries");
        expect_reg(A_SEC, 8'h00, "R2 sec");
        expect_reg(A_MIN, 8'h00, "R2 min wrap");
        expect_reg(A_HOUR, 8'h80, "R3 hour 23->00");
        expect_reg(A_DATE, 8'h01, "R5 date 31->01");
        expect_reg(A_MON, 8'h01, "R7 month 12->01");
        expect_reg(A_YEAR, 8'h00, "R7 year 99->00");
        expect_reg(A_CEN, 8'h00, "R7 century flip");
        expect_reg(A_WDAY, 8'h00, "R8 wday 6->0");
        settle();

        // R4 12-hour: 11 AM -> 12 PM, no date change
        wr(A_DATE, 8'h05); wr(A_WDAY, 8'h02);
        set_clock(8'h11, 8'h59, 8'h59);
        do_tick();
        check_carry(2, "R4 no day carry at noon");
        expect_reg(A_HOUR, 8'h32, "R4 11AM->12PM");
        expect_reg(A_DATE, 8'h05, "R4 date held at noon");
        settle();

        // R4 11 PM -> 12 AM advances date
        set_clock(8'h31, 8'h59, 8'h59);
        do_tick();
        check_carry(3, "R4 day carry at midnight");
        expect_reg(A_HOUR, 8'h12, "R4 11PM->12AM");
        expect_reg(A_DATE, 8'h06, "R4 date advance");
        expect_reg(A_WDAY, 8'h03, "R8 wday advance");
        settle();

        // R4 12 -> 01 keeps PM flag
        set_clock(8'h32, 8'h59, 8'h59);
        do_tick();
        expect_reg(A_HOUR, 8'h21, "R4 12PM->01PM");
        settle();

        // R5 30-day month
        wr(A_MON, 8'h04); wr(A_DATE, 8'h30);
        set_clock(8'hA3, 8'h59, 8'h59);
        do_tick();
        expect_reg(A_DATE, 8'h01, "R5 Apr 30 -> 01");
        expect_reg(A_MON, 8'h05, "R5 month 04->05");
        settle();

        // R6 leap year 24: Feb 28 -> 29 -> Mar 01
        wr(A_YEAR, 8'h24); wr(A_MON, 8'h02); wr(A_DATE, 8'h28);
        set_clock(8'hA3, 8'h59, 8'h59);
        do_tick();
        expect_reg(A_DATE, 8'h29, "R6 leap 28->29");
        expect_reg(A_MON, 8'h02, "R6 leap still Feb");
        settle();
        set_clock(8'hA3, 8'h59, 8'h59);
        do_tick();
        expect_reg(A_DATE, 8'h01, "R6 leap 29->01");
        expect_reg(A_MON, 8'h03, "R6 leap to Mar");
        settle();

        // R6 non-leap year 23
        wr(A_YEAR, 8'h23); wr(A_MON, 8'h02); wr(A_DATE, 8'h28);
        set_clock(8'hA3, 8'h59, 8'h59);
        do_tick();
        expect_reg(A_DATE, 8'h01, "R6 nonleap 28->01");
        expect_reg(A_MON, 8'h03, "R6 nonleap to Mar");
        settle();

        // R6 year 00 is leap
        wr(A_YEAR, 8'h00); wr(A_MON, 8'h02); wr(A_DATE, 8'h28);
        set_clock(8'hA3, 8'h59, 8'h59);
        do_tick();
        expect_reg(A_DATE, 8'h29, "R6 year00 leap");
        settle();

        // R9 host write to seconds in the cycle they are stepped
        set_clock(8'h80, 8'h10, 8'h59);
        @(negedge clk);
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
        wr_en = 1'b1; wr_addr = A_SEC; wr_data = 8'h30;
        clog[0] = carry_o;
        @(negedge clk);
        wr_en = 1'b0;
        clog[1] = carry_o;
        for (int i = 2; i < 8; i++) begin
            @(negedge clk);
            clog[i] = carry_o;
        end
        check_carry(0, "R9 no carry on write");
        expect_reg(A_SEC, 8'h30, "R9 write wins");
        expect_reg(A_MIN, 8'h10, "R9 min untouched");
        settle();

        // R11 unimplemented bits read zero
        wr(A_CEN, 8'hFF);
        wr(A_WDAY, 8'hFF);
        expect_reg(A_CEN, 8'h01, "R11 century mask");
        expect_reg(A_WDAY, 8'h07, "R11 wday mask");
        settle();

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule